// File: doc/BRIEF.md
# Music File Chunk Stream Filter

This block sits between a host that streams a music file one byte at a time and the input FIFO of a synthesizer. After a start-of-file pulse it holds back the first four bytes and reads them as a signature. A plain single-track file, signed "MThd", is passed through whole, signature included. A chunked file, signed "MMhd", is handled chunk by chunk. Each chunk opens with an eight-byte header: a four-byte ASCII tag, then a four-byte payload length stored least significant byte first.

For each chunk, the block buffers the header, decodes the tag and the length, and then takes one of two actions. It replays the header and forwards the payload, or it consumes the payload without forwarding it. The file header chunk ("MMhd") and the compressed event data chunk ("MMdd") are forwarded. The karaoke chunk ("MMly"), the extension chunk ("MMex") and any unknown tag are dropped.

The host marks the final byte of the file with a last flag. The block raises done once that byte has been consumed and every byte owed to the output has been delivered. An unknown signature or a cut-off header raises the error flag. Both byte ports use a valid/ready handshake, and output backpressure stalls the input.

Top module: `chunk_stream_filter`

## Requirements
- R1: After reset, and until the first startFile pulse, inReady, outValid, done and error are all 0.
- R2: A file whose first four bytes are 0x4D 0x54 0x68 0x64 ("MThd") appears on the output byte for byte, in order, including those four bytes. The error flag stays 0.
- R3: A file whose first four bytes are 0x4D 0x4D 0x68 0x64 ("MMhd") is processed as chunks. Its leading "MMhd" chunk is forwarded in full, with its 8-byte header and its payload.
- R4: The length field is header bytes 5 to 8, with byte 5 the least significant. It counts only the payload bytes, so a chunk spans length + 8 bytes. Lengths above 255 are honoured.
- R5: A chunk tagged 0x4D 0x4D 0x64 0x64 ("MMdd") is forwarded with its 8-byte header and then its payload. A length of 0 forwards the header alone.
- R6: A chunk tagged 0x4D 0x4D 0x6C 0x79 ("MMly") is consumed from the input, and none of its bytes reach the output.
- R7: A chunk tagged 0x4D 0x4D 0x65 0x78 ("MMex"), or with any other unrecognised tag, is consumed by counting out its length without output. Parsing resumes at the next header, and a length of 0 is valid.
- R8: Any other file signature sets error. The remaining bytes of the file are accepted and dropped, and no byte is output. Error stays set until the next startFile pulse.
- R9: While outValid is 1 and outReady is 0, inReady is 0. No byte is lost or duplicated under any output backpressure.
- R10: Once the byte flagged inLast has been consumed and all owed output has been delivered, done becomes 1 and stays 1. While done is 1, inReady and outValid are 0.
- R11: If the last byte arrives before a 4-byte signature or an 8-byte chunk header is complete, error and done are both set and the partial header is not output.
- R12: A startFile pulse restarts parsing from any state and clears done and error on the next cycle. No byte is accepted in the cycle of the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startFile | input | 1 | One-cycle pulse that starts a new file |
| inData | input | 8 | Input byte |
| inValid | input | 1 | Input byte valid |
| inLast | input | 1 | Marks the final byte of the file |
| inReady | output | 1 | Block accepts the input byte |
| outData | output | 8 | Output byte to the synthesizer FIFO |
| outValid | output | 1 | Output byte valid |
| outReady | input | 1 | Downstream accepts the output byte |
| done | output | 1 | File fully processed |
| error | output | 1 | Bad signature or truncated header |

## Verification
The bench builds the block with its default four-byte length field, so the full 32-bit little-endian length is decoded. That makes a 300-byte skipped chunk reachable, which is needed to show that the second length byte is weighted correctly. It also reaches zero-length chunks of both the forwarded and the dropped kinds. Files are driven with random input gaps and random output stalls, including a long hold of outReady low in the middle of a plain stream. A restart is issued while a karaoke chunk is only partly consumed.

// File: rtl/chunk_filter_pkg.sv
package chunk_filter_pkg;

  // tag and signature width is fixed by the file format
  localparam int TAG_BYTES = 4;

  localparam logic [31:0] SIG_PLAIN = "MThd";
  localparam logic [31:0] TAG_HEAD  = "MMhd";
  localparam logic [31:0] TAG_DATA  = "MMdd";

  typedef enum logic [3:0] {
    S_IDLE,
    S_SIG,
    S_HEAD,
    S_REPLAY,
    S_PASS,
    S_STREAM,
    S_SKIP,
    S_ERR,
    S_DONE
  } filtState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrHead;
    logic capture;
    logic startReplay;
    logic replayWide;
    logic stepReplay;
    logic loadRemain;
    logic decRemain;
    logic selReplay;
    logic selPass;
  } ctrlStrobe_t;

  // flags from datapath to control
  typedef struct packed {
    logic headTag;
    logic headFull;
    logic sigPlain;
    logic sigChunked;
    logic tagForward;
    logic lenZero;
    logic remainOne;
    logic replayLast;
  } dpStatus_t;

endpackage

// File: rtl/chunk_filter_dp.sv
module chunk_filter_dp
  import chunk_filter_pkg::*;
#(
  parameter int LEN_BYTES = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  inData,
  input  logic        inValid,
  input  ctrlStrobe_t strb,
  output logic [7:0]  outData,
  output logic        outValid,
  output dpStatus_t   stat
);

  localparam int HDR_BYTES = TAG_BYTES + LEN_BYTES;
  localparam int LEN_W     = 8 * LEN_BYTES;
  localparam int CNT_W     = $clog2(HDR_BYTES + 1);

  logic [7:0]       hdr [HDR_BYTES];
  logic [CNT_W-1:0] headCnt;
  logic [CNT_W-1:0] replayCnt;
  logic [CNT_W-1:0] replayEnd;
  logic [LEN_W-1:0] remain;
  logic [LEN_W-1:0] lenField;
  logic [31:0]      tagWord;
  logic [7:0]       replayByte;

  // header byte store, written at the current fill position
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < HDR_BYTES; i++) hdr[i] <= '0;
    end else if (strb.capture) begin
      for (int i = 0; i < HDR_BYTES; i++)
        if (headCnt == CNT_W'(i)) hdr[i] <= inData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              headCnt <= '0;
    else if (strb.clrHead)  headCnt <= '0;
    else if (strb.capture)  headCnt <= headCnt + 1'b1;
  end

  // tag bytes arrive first-to-last as most to least significant
  assign tagWord = {hdr[0], hdr[1], hdr[2], hdr[3]};

  // length field: first length byte is the least significant
  for (genvar g = 0; g < LEN_BYTES; g++) begin : gLen
    assign lenField[8*g +: 8] = hdr[TAG_BYTES + g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                remain <= '0;
    else if (strb.loadRemain) remain <= lenField;
    else if (strb.decRemain)  remain <= remain - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      replayCnt <= '0;
      replayEnd <= '0;
    end else if (strb.startReplay) begin
      replayCnt <= '0;
      replayEnd <= strb.replayWide ? CNT_W'(HDR_BYTES) : CNT_W'(TAG_BYTES);
    end else if (strb.stepReplay) begin
      replayCnt <= replayCnt + 1'b1;
    end
  end

  always_comb begin
    replayByte = '0;
    for (int i = 0; i < HDR_BYTES; i++)
      if (replayCnt == CNT_W'(i)) replayByte = hdr[i];
  end

  assign outData  = strb.selReplay ? replayByte : inData;
  assign outValid = strb.selReplay | (strb.selPass & inValid);

  assign stat.headTag    = (headCnt == CNT_W'(TAG_BYTES));
  assign stat.headFull   = (headCnt == CNT_W'(HDR_BYTES));
  assign stat.sigPlain   = (tagWord == SIG_PLAIN);
  assign stat.sigChunked = (tagWord == TAG_HEAD);
  assign stat.tagForward = (tagWord == TAG_HEAD) || (tagWord == TAG_DATA);
  assign stat.lenZero    = (lenField == '0);
  assign stat.remainOne  = (remain == LEN_W'(1));
  assign stat.replayLast = (replayCnt == replayEnd - 1'b1);

endmodule

// File: rtl/chunk_filter_ctrl.sv
module chunk_filter_ctrl
  import chunk_filter_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startFile,
  input  logic        inValid,
  input  logic        inLast,
  input  logic        outReady,
  input  dpStatus_t   stat,
  output ctrlStrobe_t strb,
  output logic        inReady,
  output logic        done,
  output logic        error
);

  filtState_t state, nextState;
  filtState_t afterState, nextAfter;
  logic       lastSeen;
  logic       errorR;
  logic       setErr;
  logic       accept;
  logic       readyC;

  always_comb begin
    strb      = '0;
    nextState = state;
    nextAfter = afterState;
    setErr    = 1'b0;

    unique case (state)
      S_SIG:            readyC = !stat.headTag && !lastSeen;
      S_HEAD:           readyC = !stat.headFull && !lastSeen;
      S_PASS, S_STREAM: readyC = outReady;
      S_SKIP, S_ERR:    readyC = 1'b1;
      default:          readyC = 1'b0;
    endcase
    if (startFile) readyC = 1'b0;

    accept          = inValid && readyC;
    strb.capture    = accept && (state == S_SIG || state == S_HEAD);
    strb.selReplay  = (state == S_REPLAY);
    strb.selPass    = (state == S_PASS) || (state == S_STREAM);
    strb.stepReplay = (state == S_REPLAY) && outReady;
    strb.decRemain  = accept && (state == S_PASS || state == S_SKIP);

    if (startFile) begin
      nextState    = S_SIG;
      strb.clrHead = 1'b1;
    end else begin
      unique case (state)
        S_SIG: begin
          if (stat.headTag) begin
            if (stat.sigPlain) begin
              strb.startReplay = 1'b1;
              nextState        = S_REPLAY;
              nextAfter        = lastSeen ? S_DONE : S_STREAM;
            end else if (stat.sigChunked) begin
              nextState = S_HEAD;
            end else begin
              setErr    = 1'b1;
              nextState = lastSeen ? S_DONE : S_ERR;
            end
          end else if (lastSeen) begin
            setErr    = 1'b1;
            nextState = S_DONE;
          end
        end
        S_HEAD: begin
          if (stat.headFull) begin
            strb.loadRemain = 1'b1;
            strb.clrHead    = 1'b1;
            if (stat.tagForward) begin
              strb.startReplay = 1'b1;
              strb.replayWide  = 1'b1;
              nextState        = S_REPLAY;
              nextAfter        = lastSeen ? S_DONE :
                                 (stat.lenZero ? S_HEAD : S_PASS);
            end else begin
              nextState = lastSeen ? S_DONE :
                          (stat.lenZero ? S_HEAD : S_SKIP);
            end
          end else if (lastSeen) begin
            setErr    = 1'b1;
            nextState = S_DONE;
          end
        end
        S_REPLAY: begin
          if (outReady && stat.replayLast) nextState = afterState;
        end
        S_PASS, S_SKIP: begin
          if (accept) begin
            if (inLast)              nextState = S_DONE;
            else if (stat.remainOne) nextState = S_HEAD;
          end
        end
        S_STREAM, S_ERR: begin
          if (accept && inLast) nextState = S_DONE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_IDLE;
      afterState <= S_IDLE;
      lastSeen   <= 1'b0;
      errorR     <= 1'b0;
    end else begin
      state      <= nextState;
      afterState <= nextAfter;
      if (startFile) begin
        lastSeen <= 1'b0;
        errorR   <= 1'b0;
      end else begin
        if (strb.capture && inLast) lastSeen <= 1'b1;
        if (setErr)                 errorR   <= 1'b1;
      end
    end
  end

  assign inReady = readyC;
  assign done    = (state == S_DONE);
  assign error   = errorR;

endmodule

// File: rtl/chunk_stream_filter.sv
module chunk_stream_filter
  import chunk_filter_pkg::*;
#(
  parameter int LEN_BYTES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startFile,
  input  logic [7:0] inData,
  input  logic       inValid,
  input  logic       inLast,
  output logic       inReady,
  output logic [7:0] outData,
  output logic       outValid,
  input  logic       outReady,
  output logic       done,
  output logic       error
);

  ctrlStrobe_t strb;
  dpStatus_t   stat;

  chunk_filter_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startFile (startFile),
    .inValid   (inValid),
    .inLast    (inLast),
    .outReady  (outReady),
    .stat      (stat),
    .strb      (strb),
    .inReady   (inReady),
    .done      (done),
    .error     (error)
  );

  chunk_filter_dp #(.LEN_BYTES(LEN_BYTES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .inData   (inData),
    .inValid  (inValid),
    .strb     (strb),
    .outData  (outData),
    .outValid (outValid),
    .stat     (stat)
  );

endmodule

// File: rtl/chunk_filter_chk.sv
module chunk_filter_chk (
  input logic clk,
  input logic rstN,
  input logic startFile,
  input logic inReady,
  input logic outValid,
  input logic outReady,
  input logic done,
  input logic error
);

  // R9: a stalled output must hold the input
  a_r9_stall_blocks_input: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> !inReady);

  // R10: a finished file is quiet on both ports
  a_r10_done_quiet: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!inReady && !outValid));

  // R10: done holds until a restart
  a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (done && !startFile) |=> done);

  // R8: error holds until a restart
  a_r8_error_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (error && !startFile) |=> error);

  // R8: nothing is output once the file is in error
  a_r8_error_silent: assert property (@(posedge clk) disable iff (!rstN)
    error |-> !outValid);

  // R12: a restart clears both flags and accepts nothing in its cycle
  a_r12_restart_clears: assert property (@(posedge clk) disable iff (!rstN)
    startFile |=> (!done && !error));

  a_r12_restart_no_accept: assert property (@(posedge clk) disable iff (!rstN)
    startFile |-> !inReady);

endmodule

bind chunk_stream_filter chunk_filter_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .startFile (startFile),
  .inReady   (inReady),
  .outValid  (outValid),
  .outReady  (outReady),
  .done      (done),
  .error     (error)
);

// File: tb/sim_chunk_stream_filter.sv
module sim_chunk_stream_filter;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startFile = 1'b0;
  logic [7:0] inData = '0;
  logic       inValid = 1'b0;
  logic       inLast = 1'b0;
  logic       inReady;
  logic [7:0] outData;
  logic       outValid;
  logic       outReady = 1'b0;
  logic       done;
  logic       error;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;
  bit holdLow = 0;
  logic [15:0] lfsr = 16'hACE1;

  logic [7:0] fileQ[$];
  logic [7:0] expQ[$];

  chunk_stream_filter u0 (
    .clk(clk), .rstN(rstN), .startFile(startFile),
    .inData(inData), .inValid(inValid), .inLast(inLast), .inReady(inReady),
    .outData(outData), .outValid(outValid), .outReady(outReady),
    .done(done), .error(error)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic putTag(input logic [31:0] t, input bit fwd);
    for (int k = 3; k >= 0; k--) begin
      fileQ.push_back(t[8*k +: 8]);
      if (fwd) expQ.push_back(t[8*k +: 8]);
    end
  endtask

  task automatic addChunk(input logic [31:0] tag, input int len, input bit fwd);
    logic [31:0] l;
    logic [7:0]  b;
    l = len;
    putTag(tag, fwd);
    for (int k = 0; k < 4; k++) begin
      fileQ.push_back(l[8*k +: 8]);
      if (fwd) expQ.push_back(l[8*k +: 8]);
    end
    for (int i = 0; i < len; i++) begin
      b = 8'(i * 7 + len);
      fileQ.push_back(b);
      if (fwd) expQ.push_back(b);
    end
  endtask

  // output ready pattern and shared pseudo-random source
  initial begin
    forever begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      outReady = holdLow ? 1'b0 : (lfsr[1:0] != 2'b00);
    end
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      #4;
      if (rstN && outValid && outReady) begin
        if (expQ.size() == 0) begin
          check(0, "R6/R7/R8 unexpected output byte", outData, -1);
        end else begin
          logic [7:0] e;
          e = expQ.pop_front();
          check(outData == e, "R2/R3/R5 output byte", outData, e);
        end
      end
      if (rstN && outValid && !outReady)
        check(!inReady, "R9 input held while output stalled", inReady, 0);
    end
  end

  task automatic pulseStart();
    @(negedge clk);
    startFile = 1'b1;
    #4;
    check(!inReady, "R12 no accept during startFile", inReady, 0);
    @(negedge clk);
    startFile = 1'b0;
    #4;
    check(!done && !error, "R12 flags cleared after startFile", {done, error}, 0);
  endtask

  task automatic sendAll(input bit markLast);
    int n;
    n = fileQ.size();
    for (int i = 0; i < n; i++) begin
      bit acc;
      acc = 0;
      while (!acc) begin
        @(negedge clk);
        if (lfsr[5:4] == 2'b00) begin
          inValid = 1'b0;
        end else begin
          inValid = 1'b1;
          inData  = fileQ[i];
          inLast  = markLast && (i == n - 1);
          #4;
          acc = inReady;
        end
      end
    end
    @(negedge clk);
    inValid = 1'b0;
    inLast  = 1'b0;
    fileQ.delete();
  endtask

  task automatic finishFile(input bit expErr, input string req);
    int n;
    n = 0;
    while (!done && n < 4000) begin
      @(negedge clk);
      n++;
    end
    #4;
    check(done, {req, " R10 done raised"}, done, 1);
    check(expQ.size() == 0, {req, " all expected bytes delivered"}, expQ.size(), 0);
    check(error == expErr, {req, " error flag"}, error, expErr);
    check(!inReady && !outValid, {req, " R10 quiet when done"}, {inReady, outValid}, 0);
    expQ.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL R10 watchdog expired: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    #4;
    // R1: idle after reset
    check(!inReady && !outValid && !done && !error, "R1 reset state",
          {inReady, outValid, done, error}, 0);

    // R2: plain file passes whole, including during a long stall (R9)
    pulseStart();
    putTag("MThd", 1);
    for (int i = 0; i < 40; i++) begin
      fileQ.push_back(8'(i * 13 + 1));
      expQ.push_back(8'(i * 13 + 1));
    end
    fork
      sendAll(1);
      begin
        repeat (20) @(negedge clk);
        holdLow = 1;
        repeat (30) @(negedge clk);
        holdLow = 0;
      end
    join
    finishFile(0, "R2 plain file");

    // R3 R5 R6 R7: mixed chunked file
    pulseStart();
    addChunk("MMhd", 3, 1);
    addChunk("MMly", 5, 0);
    addChunk("MMdd", 6, 1);
    addChunk("MMex", 0, 0);
    addChunk("MMex", 2, 0);
    sendAll(1);
    finishFile(0, "R3 R5 R6 R7 chunked file");

    // R4 R7 R5: long unknown chunk, zero-length data chunk
    pulseStart();
    addChunk("MMhd", 1, 1);
    addChunk("ABCD", 300, 0);
    addChunk("MMdd", 0, 1);
    addChunk("MMdd", 4, 1);
    sendAll(1);
    finishFile(0, "R4 R5 R7 long length");

    // R8: bad signature
    pulseStart();
    putTag("RIFF", 0);
    for (int i = 0; i < 12; i++) fileQ.push_back(8'(i));
    sendAll(1);
    finishFile(1, "R8 bad signature");

    // R11: truncated chunk header
    pulseStart();
    putTag("MMhd", 0);
    fileQ.push_back(8'h02);
    fileQ.push_back(8'h00);
    sendAll(1);
    finishFile(1, "R11 truncated header");

    // R11: truncated signature
    pulseStart();
    fileQ.push_back(8'h4D);
    fileQ.push_back(8'h54);
    sendAll(1);
    finishFile(1, "R11 truncated signature");

    // R12: restart while a karaoke chunk is half consumed
    pulseStart();
    addChunk("MMhd", 2, 1);
    putTag("MMly", 0);
    fileQ.push_back(8'd20);
    fileQ.push_back(8'd0);
    fileQ.push_back(8'd0);
    fileQ.push_back(8'd0);
    for (int i = 0; i < 5; i++) fileQ.push_back(8'hEE);
    sendAll(0);
    repeat (40) @(negedge clk);
    #4;
    check(expQ.size() == 0, "R12 R6 partial file output before restart", expQ.size(), 0);
    check(!done, "R12 not done mid file", done, 0);
    pulseStart();
    putTag("MThd", 1);
    for (int i = 0; i < 6; i++) begin
      fileQ.push_back(8'(200 + i));
      expQ.push_back(8'(200 + i));
    end
    sendAll(1);
    finishFile(0, "R12 restart then plain file");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule